// File: doc/BRIEF.md
# Multichannel Memory-to-Memory DMA Controller

This block moves data between two memory regions on behalf of software, with no processor involvement once a channel is started. Each of several channels keeps its own source pointer, destination pointer, remaining-transfer count and control word. A shared operation word holds the global run enable and two sticky halt flags: one for a non-maskable interrupt and one for an address fault. For each transfer, the controller reads one beat of 1, 2 or 4 bytes from the source over a single-beat request/acknowledge memory port. It then writes that beat to the destination and advances both pointers by the beat size.

Software programs a channel while its enable bit is clear, then sets the channel enable and the global enable in either order. When the count runs out, the channel raises its end flag and goes quiet. An NMI or an address fault stops every channel with its state frozen at the next addresses and the remaining count, so software can inspect the state and resume. Clearing the global enable lets the transfer in flight finish before the controller goes idle.

The register window is selected by `cfg_addr`. When the top bit is 1, the access goes to the operation word. Otherwise the channel-select bits sit above the two low bits, and the low bits pick the register: 0 source, 1 destination, 2 count, 3 control. The control word holds the channel enable in bit 0, the end flag in bit 1 and the size code in bits 3:2. The operation word holds the global enable in bit 0, the NMI flag in bit 1 and the address-fault flag in bit 2.

Top module: `dma_ctrl`

## Requirements
- R1: A channel issues bus cycles only while both the global enable (operation bit 0) and its own enable (control bit 0) are 1, and the order in which the two are set does not matter; after reset all registers read 0 and `mem_req` is 0.
- R2: A high `nmi` input sets the NMI flag (operation bit 1) on the next clock, whether or not a transfer is running; it takes precedence over a software clear in the same cycle.
- R3: While the NMI flag or the address-fault flag is 1, no transfer starts, and a channel's count keeps its programmed value.
- R4: If the NMI flag is set while a source read is in flight, the write for that beat is not issued; the channel keeps enable 1 and end flag 0, its count shows the transfers still remaining, and its pointers show the next addresses to be accessed.
- R5: A source or destination address not aligned to the beat size, or a beat that would touch any byte at or above 0xF000, sets the address-fault flag (operation bit 2) and starts no bus cycle, leaving the channel's registers unchanged.
- R6: Clearing the global enable does not cut short the transfer in progress; that transfer's write completes and is counted, and no further transfer starts.
- R7: When a transfer brings the count from 1 to 0, the channel sets its end flag (control bit 1), keeps its enable bit, and issues no more cycles.
- R8: While a channel's enable bit is 1, writes to its source, destination and count registers are ignored, and a control write changes only the enable bit.
- R9: A count of 0 written by software means 2^8 = 256 transfers.
- R10: When several channels are ready, the lowest-numbered channel is served first, and the arbiter chooses only between complete transfers.
- R11: Size code 0 moves 1 byte, code 1 moves 2 bytes, codes 2 and 3 move 4 bytes. Data is carried right-justified on the data buses, and both pointers advance by the beat size after each write.
- R12: Writing 0 to the NMI or address-fault flag clears it; writing 1 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi | input | 1 | Non-maskable interrupt event, sampled each clock |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register select (operation word or channel/register) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| mem_req | output | 1 | Memory cycle request, held until acknowledged |
| mem_we | output | 1 | 1 for a destination write, 0 for a source read |
| mem_addr | output | 16 | Byte address of the current beat |
| mem_size | output | 2 | Size code of the current beat |
| mem_wdata | output | 32 | Write data, right-justified |
| mem_rdata | input | 32 | Read data, right-justified, valid with `mem_ack` |
| mem_ack | input | 1 | Completion of the requested memory cycle |

## Verification
The copy function is run with 1-byte and 4-byte beats, with an all-zero count that must mean the full 256 transfers, and with two channels ready together. These cases separate step-size errors, count-encoding errors and priority errors. Halts are provoked at different points: an NMI while idle, an NMI during a source read, a global-enable clear during a write, and both a misaligned and an out-of-range pointer. The frozen count and pointers then show whether the beat in flight was wrongly committed or wrongly dropped. Register writes to a running channel and writes of 1 to the flags confirm that those writes leave the state untouched.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } phase_e;

    localparam logic [1:0] RG_SRC = 2'd0;
    localparam logic [1:0] RG_DST = 2'd1;
    localparam logic [1:0] RG_CNT = 2'd2;
    localparam logic [1:0] RG_CTL = 2'd3;

    // Beat size in bytes for a size code; codes 2 and 3 both mean 4 bytes.
    function automatic logic [2:0] beat_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_arbiter.sv
module dma_arbiter #(
    parameter int NCH = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] ready,
    output logic           any,
    output logic [CHW-1:0] pick
);
    logic [NCH-1:0] lower;
    logic [NCH-1:0] gnt;

    // Fixed priority: a channel wins only if no lower index is ready.
    for (genvar i = 0; i < NCH; i++) begin : g_pri
        if (i == 0) begin : g_first
            assign lower[i] = 1'b0;
        end else begin : g_rest
            assign lower[i] = lower[i-1] | ready[i-1];
        end
        assign gnt[i] = ready[i] & ~lower[i];
    end

    always_comb begin
        pick = '0;
        for (int i = 0; i < NCH; i++) begin
            if (gnt[i]) pick = CHW'(i);
        end
    end

    assign any = |ready;

endmodule

// File: rtl/dma_addr_check.sv
module dma_addr_check #(
    parameter int          AW    = 16,
    parameter int unsigned LIMIT = 32'h0000_F000
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    output logic          bad
);
    import dma_pkg::*;

    logic [1:0]  low_mask;
    logic [AW:0] last_excl;

    always_comb begin
        case (size)
            2'd0:    low_mask = 2'b00;
            2'd1:    low_mask = 2'b01;
            default: low_mask = 2'b11;
        endcase
        last_excl = {1'b0, addr} + (AW+1)'(beat_bytes(size));
        bad = (|(addr[1:0] & low_mask)) || (last_excl > (AW+1)'(LIMIT));
    end

endmodule

// File: rtl/dma_ctrl.sv
module dma_ctrl import dma_pkg::*; #(
    parameter int          NCH        = 4,
    parameter int          AW         = 16,
    parameter int          CW         = 8,
    parameter int          DW         = 32,
    parameter int unsigned ADDR_LIMIT = 32'h0000_F000,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int RAW = CHW + 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           nmi,
    input  logic           cfg_we,
    input  logic [RAW-1:0] cfg_addr,
    input  logic [DW-1:0]  cfg_wdata,
    output logic [DW-1:0]  cfg_rdata,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [1:0]     mem_size,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    input  logic           mem_ack
);

    typedef struct packed {
        phase_e                  ph;
        logic [CHW-1:0]          cur;
        logic [DW-1:0]           hold;
        logic                    run;
        logic                    nmif;
        logic                    aef;
        logic [NCH-1:0][AW-1:0]  src;
        logic [NCH-1:0][AW-1:0]  dst;
        logic [NCH-1:0][CW-1:0]  cnt;
        logic [NCH-1:0]          en;
        logic [NCH-1:0]          te;
        logic [NCH-1:0][1:0]     sz;
    } state_t;

    state_t s_q, s_d;

    // Register select decode
    logic           sel_op;
    logic [CHW-1:0] sel_ch;
    logic [1:0]     sel_rg;
    logic           sel_ok;

    assign sel_op = cfg_addr[RAW-1];
    assign sel_ch = cfg_addr[CHW+1:2];
    assign sel_rg = cfg_addr[1:0];
    assign sel_ok = (int'(sel_ch) < NCH);

    // Arbitration among channels ready to move a beat
    logic [NCH-1:0] ready;
    logic           any_ready;
    logic [CHW-1:0] pick;

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            ready[i] = s_q.run & s_q.en[i] & ~s_q.te[i] & ~s_q.nmif & ~s_q.aef;
        end
    end

    dma_arbiter #(.NCH(NCH)) u_arb (
        .ready (ready),
        .any   (any_ready),
        .pick  (pick)
    );

    // Address legality of the candidate channel
    logic src_bad, dst_bad;

    dma_addr_check #(.AW(AW), .LIMIT(ADDR_LIMIT)) u_chk_src (
        .addr (s_q.src[pick]),
        .size (s_q.sz[pick]),
        .bad  (src_bad)
    );

    dma_addr_check #(.AW(AW), .LIMIT(ADDR_LIMIT)) u_chk_dst (
        .addr (s_q.dst[pick]),
        .size (s_q.sz[pick]),
        .bad  (dst_bad)
    );

    logic [AW-1:0] step;
    assign step = AW'(beat_bytes(s_q.sz[s_q.cur]));

    always_comb begin
        s_d = s_q;

        // Software register writes
        if (cfg_we) begin
            if (sel_op) begin
                s_d.run = cfg_wdata[0];
                if (!cfg_wdata[1]) s_d.nmif = 1'b0;
                if (!cfg_wdata[2]) s_d.aef  = 1'b0;
            end else if (sel_ok) begin
                case (sel_rg)
                    RG_SRC: if (!s_q.en[sel_ch]) s_d.src[sel_ch] = cfg_wdata[AW-1:0];
                    RG_DST: if (!s_q.en[sel_ch]) s_d.dst[sel_ch] = cfg_wdata[AW-1:0];
                    RG_CNT: if (!s_q.en[sel_ch]) s_d.cnt[sel_ch] = cfg_wdata[CW-1:0];
                    default: begin
                        s_d.en[sel_ch] = cfg_wdata[0];
                        if (!s_q.en[sel_ch]) begin
                            s_d.te[sel_ch] = cfg_wdata[1];
                            s_d.sz[sel_ch] = cfg_wdata[3:2];
                        end
                    end
                endcase
            end
        end

        if (nmi) s_d.nmif = 1'b1;

        // Transfer sequencing
        case (s_q.ph)
            PH_IDLE: begin
                if (any_ready) begin
                    s_d.cur = pick;
                    if (src_bad || dst_bad) s_d.aef = 1'b1;
                    else                    s_d.ph  = PH_READ;
                end
            end
            PH_READ: begin
                if (mem_ack) begin
                    s_d.hold = mem_rdata;
                    s_d.ph   = (s_q.nmif || nmi) ? PH_IDLE : PH_WRITE;
                end
            end
            PH_WRITE: begin
                if (mem_ack) begin
                    s_d.src[s_q.cur] = s_q.src[s_q.cur] + step;
                    s_d.dst[s_q.cur] = s_q.dst[s_q.cur] + step;
                    s_d.cnt[s_q.cur] = s_q.cnt[s_q.cur] - 1'b1;
                    if (s_q.cnt[s_q.cur] == CW'(1)) s_d.te[s_q.cur] = 1'b1;
                    s_d.ph = PH_IDLE;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Outputs
    assign mem_req   = (s_q.ph != PH_IDLE);
    assign mem_we    = (s_q.ph == PH_WRITE);
    assign mem_addr  = (s_q.ph == PH_WRITE) ? s_q.dst[s_q.cur] : s_q.src[s_q.cur];
    assign mem_size  = s_q.sz[s_q.cur];
    assign mem_wdata = s_q.hold;

    always_comb begin
        cfg_rdata = '0;
        if (sel_op) begin
            cfg_rdata[2:0] = {s_q.aef, s_q.nmif, s_q.run};
        end else if (sel_ok) begin
            case (sel_rg)
                RG_SRC:  cfg_rdata[AW-1:0] = s_q.src[sel_ch];
                RG_DST:  cfg_rdata[AW-1:0] = s_q.dst[sel_ch];
                RG_CNT:  cfg_rdata[CW-1:0] = s_q.cnt[sel_ch];
                default: cfg_rdata[3:0]    = {s_q.sz[sel_ch], s_q.te[sel_ch], s_q.en[sel_ch]};
            endcase
        end
    end

    // Assertions
    p_start_needs_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_READ && $past(s_q.ph) == PH_IDLE) |-> $past(s_q.run));

    p_nmi_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        nmi |=> s_q.nmif);

    p_nmi_blocks_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.nmif && s_q.ph == PH_IDLE) |=> (s_q.ph == PH_IDLE));

    p_nmi_drops_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_READ && mem_ack && s_q.nmif) |=> !mem_req);

    p_fault_halts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.aef && s_q.ph == PH_IDLE) |=> !mem_req);

    p_write_completes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_WRITE && !mem_ack) |=> (mem_req && mem_we));

    p_flag_write_one_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && sel_op && !s_q.nmif && !nmi) |=> !s_q.nmif);

    for (genvar i = 0; i < NCH; i++) begin : g_ch_prop
        p_end_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (s_q.ph == PH_WRITE && s_q.cur == CHW'(i) && mem_ack && s_q.cnt[i] == CW'(1))
            |=> (s_q.te[i] && !mem_req));

        p_zero_is_max_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (s_q.ph == PH_WRITE && s_q.cur == CHW'(i) && mem_ack && s_q.cnt[i] == '0)
            |=> (s_q.cnt[i] == '1 && !s_q.te[i]));

        p_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (s_q.ph == PH_WRITE && s_q.cur == CHW'(i) && mem_ack)
            |=> (s_q.src[i] == $past(s_q.src[i]) + $past(step)));

        p_locked_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && !sel_op && sel_ch == CHW'(i) && sel_rg == RG_SRC
             && s_q.en[i] && s_q.ph == PH_IDLE) |=> $stable(s_q.src[i]));
    end

endmodule

// File: tb/sim_dma_ctrl.sv
`timescale 1ns/1ps
module sim_dma_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [1:0]  mem_size;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    always #4 clk = ~clk;

    dma_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .nmi(nmi),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] mem [1024];
    int wcnt = 0;
    int rn = 0;
    int rlog [16];

    function automatic int nbytes(input logic [1:0] c);
        return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
    endfunction

    // Memory model: acknowledges one clock after a request
    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                for (int b = 0; b < nbytes(mem_size); b++)
                    mem[(int'(mem_addr) + b) % 1024] = mem_wdata[8*b +: 8];
            end else begin
                logic [31:0] r;
                r = '0;
                for (int b = 0; b < nbytes(mem_size); b++)
                    r[8*b +: 8] = mem[(int'(mem_addr) + b) % 1024];
                mem_rdata <= r;
            end
        end else begin
            mem_ack <= 1'b0;
        end
        if (mem_req && mem_ack && mem_we) wcnt = wcnt + 1;
        if (mem_req && mem_ack && !mem_we) begin
            if (rn < 16) rlog[rn] = int'(mem_addr);
            rn = rn + 1;
        end
    end

    localparam logic [4:0] OP = 5'b10000;
    function automatic logic [4:0] ra(input int ch, input int rg);
        return {1'b0, 2'(ch), 2'(rg)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic wait_end(input int ch, input int limit);
        logic [31:0] v;
        for (int k = 0; k < limit; k++) begin
            rd(ra(ch, 3), v);
            if (v[1]) break;
        end
    endtask

    task automatic setup(input int ch, input int s, input int d, input int c, input logic [1:0] sz);
        wr(ra(ch, 0), 32'(s));
        wr(ra(ch, 1), 32'(d));
        wr(ra(ch, 2), 32'(c));
        wr(ra(ch, 3), {28'd0, sz, 2'b00});
    endtask

    task automatic cleanup(input int ch);
        wr(ra(ch, 3), 32'd0);
        wr(OP, 32'd0);
        wr(ra(ch, 3), 32'd0);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(OP, v);         chk("R1 reset op", v, 0);
        rd(ra(2, 3), v);   chk("R1 reset ctl", v, 0);
        chk("R1 reset req", 32'(mem_req), 0);
    endtask

    task automatic t_basic;
        logic [31:0] v;
        setup(0, 'h10, 'h40, 4, 2'd0);
        wr(OP, 1);
        repeat (20) @(negedge clk);
        chk("R1 run without channel enable", 32'(rn), 0);
        wr(ra(0, 3), 32'h1);
        wait_end(0, 200);
        for (int i = 0; i < 4; i++) chk("R11 byte copy", 32'(mem['h40 + i]), 32'(mem['h10 + i]));
        rd(ra(0, 0), v); chk("R11 src step", v, 'h14);
        rd(ra(0, 1), v); chk("R11 dst step", v, 'h44);
        rd(ra(0, 2), v); chk("R7 count zero", v, 0);
        rd(ra(0, 3), v); chk("R7 end flag kept enable", v, 'h3);
        wr(ra(0, 0), 'h55);
        rd(ra(0, 0), v); chk("R8 src locked", v, 'h14);
        wr(ra(0, 3), 0);
        rd(ra(0, 3), v); chk("R8 ctl only enable", v, 'h2);
        cleanup(0);
    endtask

    task automatic t_size4;
        logic [31:0] v;
        setup(1, 'h20, 'h80, 2, 2'd2);
        wr(OP, 1);
        wr(ra(1, 3), {28'd0, 2'd2, 2'b01});
        wait_end(1, 200);
        for (int i = 0; i < 8; i++) chk("R11 word copy", 32'(mem['h80 + i]), 32'(mem['h20 + i]));
        rd(ra(1, 0), v); chk("R11 src step 4", v, 'h28);
        rd(ra(1, 1), v); chk("R11 dst step 4", v, 'h88);
        cleanup(1);
    endtask

    task automatic t_priority;
        setup(2, 'h00, 'h300, 2, 2'd0);
        setup(3, 'h08, 'h308, 2, 2'd0);
        wr(ra(3, 3), 32'h1);
        wr(ra(2, 3), 32'h1);
        rn = 0;
        wr(OP, 1);
        wait_end(3, 200);
        chk("R10 first read", 32'(rlog[0]), 'h00);
        chk("R10 second read", 32'(rlog[1]), 'h01);
        chk("R10 third read", 32'(rlog[2]), 'h08);
        chk("R10 fourth read", 32'(rlog[3]), 'h09);
        cleanup(2);
        cleanup(3);
    endtask

    task automatic t_max;
        logic [31:0] v;
        setup(0, 'h000, 'h200, 0, 2'd0);
        wcnt = 0;
        wr(ra(0, 3), 32'h1);
        wr(OP, 1);
        wait_end(0, 3000);
        chk("R9 transfers for zero count", 32'(wcnt), 256);
        rd(ra(0, 1), v); chk("R9 dst after max", v, 'h300);
        chk("R9 last byte", 32'(mem['h2FF]), 32'(mem['h0FF]));
        cleanup(0);
    endtask

    task automatic t_fault;
        logic [31:0] v;
        setup(1, 'h11, 'h40, 2, 2'd1);
        rn = 0;
        wr(ra(1, 3), {28'd0, 2'd1, 2'b01});
        wr(OP, 1);
        repeat (10) @(negedge clk);
        rd(OP, v);       chk("R5 misaligned sets fault", v, 'h5);
        rd(ra(1, 2), v); chk("R5 count untouched", v, 2);
        chk("R5 no bus cycle", 32'(rn), 0);
        wr(ra(1, 3), 0);
        wr(OP, 1);
        rd(OP, v);       chk("R12 fault cleared by 0", v, 'h1);
        wr(OP, 0);
        setup(1, 'h10, 'hF000, 1, 2'd0);
        wr(ra(1, 3), 32'h1);
        wr(OP, 1);
        repeat (10) @(negedge clk);
        rd(OP, v);       chk("R5 range fault", v, 'h5);
        chk("R5 no cycle on range fault", 32'(rn), 0);
        cleanup(1);
    endtask

    task automatic t_nmi_idle;
        logic [31:0] v;
        wr(OP, 32'h7);
        rd(OP, v);       chk("R12 writing 1 keeps flags clear", v, 'h1);
        @(negedge clk) nmi = 1'b1;
        @(negedge clk) nmi = 1'b0;
        rd(OP, v);       chk("R2 nmi while idle", v, 'h3);
        setup(0, 'h10, 'h50, 3, 2'd0);
        rn = 0;
        wr(ra(0, 3), 32'h1);
        repeat (20) @(negedge clk);
        rd(ra(0, 2), v); chk("R3 count kept", v, 3);
        chk("R3 no start", 32'(rn), 0);
        wr(OP, 32'h1);
        wait_end(0, 200);
        rd(ra(0, 2), v); chk("R12 resumes after clear", v, 0);
        cleanup(0);
    endtask

    task automatic t_nmi_during;
        logic [31:0] v;
        mem['h62] = 8'hA5;
        setup(0, 'h30, 'h60, 5, 2'd0);
        wcnt = 0;
        wr(ra(0, 3), 32'h1);
        wr(OP, 1);
        while (wcnt < 2) @(negedge clk);
        @(negedge clk);
        while (!(mem_req && !mem_we)) @(negedge clk);
        nmi = 1'b1;
        @(negedge clk) nmi = 1'b0;
        repeat (10) @(negedge clk);
        chk("R4 no write for aborted beat", 32'(wcnt), 2);
        rd(ra(0, 2), v); chk("R4 remaining count", v, 3);
        rd(ra(0, 0), v); chk("R4 next src", v, 'h32);
        rd(ra(0, 1), v); chk("R4 next dst", v, 'h62);
        rd(ra(0, 3), v); chk("R4 enable kept end clear", v, 'h1);
        chk("R4 dst byte untouched", 32'(mem['h62]), 'hA5);
        cleanup(0);
    endtask

    task automatic t_run_clear;
        logic [31:0] v;
        setup(0, 'h100, 'h180, 4, 2'd2);
        wcnt = 0;
        wr(ra(0, 3), {28'd0, 2'd2, 2'b01});
        wr(OP, 1);
        while (wcnt < 1) @(negedge clk);
        while (!(mem_req && mem_we)) @(negedge clk);
        cfg_we = 1'b1; cfg_addr = OP; cfg_wdata = 0;
        @(negedge clk) cfg_we = 1'b0;
        repeat (15) @(negedge clk);
        chk("R6 in-flight write completed", 32'(wcnt), 2);
        rd(ra(0, 2), v); chk("R6 count after stop", v, 2);
        rd(ra(0, 0), v); chk("R6 src after stop", v, 'h108);
        chk("R6 idle after stop", 32'(mem_req), 0);
        cleanup(0);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_basic;
        t_size4;
        t_priority;
        t_max;
        t_fault;
        t_nmi_idle;
        t_nmi_during;
        t_run_clear;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule